// File: doc/BRIEF.md
# SMBus register slave with strap address

This block is a byte-wide SMBus/I2C-style target that runs entirely on an oversampled system clock. Both bus lines are brought through two-flop synchronizers. START, STOP and repeated START are found by edge detection on the synchronized values. The block answers one 7-bit address. The upper three bits of that address are hard-coded to `101` and the lower four come from strap inputs, so sixteen copies can share one bus.

Behind the address sit five byte registers:

- index 0: routing selects
- index 1: emphasis levels
- index 2: equalization levels
- index 3: control
- index 4: a read-only status byte, sampled every clock from a 4-bit input

The four writable registers drive the configuration outputs directly. A write is one transfer: address, register index, data byte. A read sets the index with a write-direction transfer, then uses a repeated START and a read-direction address, and returns one byte.

The bus-enable input gates the whole target. While it is low the target never pulls SDA. Every change of its level returns all registers to their reset values. An SCL-low watchdog abandons a stalled transfer and releases the bus.

Top module: `smb_reg_slave`

## Requirements
- R1: The target acknowledges (SDA pulled low in the ninth clock) only the address whose upper bits are `101` and whose lower four bits equal `strap_i[3:0]`, with the R/W flag as bit 0. For any other address it leaves SDA released, and it does not acknowledge or act on any later byte until the next START.
- R2: A write transfer (START, address with R/W=0, index byte, data byte, STOP) acknowledges all three bytes. It updates register 0, 1, 2 or 3, which appear on `route_o`, `emph_o`, `eq_o` and `ctrl_o` respectively.
- R3: A read transfer (index set by a write-direction transfer, repeated START, address with R/W=1) acknowledges the address and returns the indexed register MSB first on SDA.
- R4: After reset, registers 0 to 2 hold 0x00 and register 3 holds 0x0F. These values appear both on the output ports and in reads.
- R5: Register 4 reads as `{4'b0000, sig_ok_i}`. A write to register 4 is acknowledged and changes no register.
- R6: A write to any index above 4 is acknowledged and changes no register. A read of any index above 4 returns 0x00.
- R7: While `en_i` is low, SDA is never pulled low. Each change of level on `en_i` restores every writable register to its reset value.
- R8: If synchronized SCL stays low for more than `TIMEOUT_CYC` clocks, the target abandons the transfer and releases SDA. A following transfer then works normally.
- R9: The target changes its SDA drive only while synchronized SCL is low. A STOP before the data byte leaves all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Bus enable; level change clears registers |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 4 | Low four address bits |
| sig_ok_i | input | 4 | Per-input signal-present status, 1 = valid |
| route_o | output | 8 | Register 0, routing selects |
| emph_o | output | 8 | Register 1, emphasis levels |
| eq_o | output | 8 | Register 2, equalization levels |
| ctrl_o | output | 8 | Register 3, control |

## Verification
The hardest situation to reach is an SCL stall at the moment the target is itself holding SDA low. Releasing the line there is the only exit, and the host cannot end the stall with a STOP. The bench reaches it by clocking out an address byte bit by bit. It then stops before the ninth clock and checks that the acknowledge is being driven. Finally it holds SCL low past the timeout, confirms the line is released, and runs a normal transfer afterwards. A second case that is hard to reach is the enable toggle: the bench first fills the registers with non-reset data, then flips `en_i` in each direction and checks the ports after each change.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int DW       = 8;
  localparam int NRW      = 4;          // writable registers 0..NRW-1
  localparam int STAT_IDX = 4;          // read-only status index
  localparam int CTRL_IDX = 3;
  localparam int NST      = 4;          // status bits
  localparam int SW       = 4;          // strap bits
  localparam logic [2:0] ADDR_HI = 3'b101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_REG, ST_WDATA, ST_RDATA, ST_WAIT
  } smb_state_e;

  function automatic logic [DW-1:0] reg_rst(input int idx);
    return (idx == CTRL_IDX) ? 8'h0F : 8'h00;
  endfunction
endpackage

// File: rtl/smb_sync.sv
module smb_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_s_o = scl_ff[1];
  assign sda_s_o = sda_ff[1];
  assign start_o = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
  assign stop_o  = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
  assign rise_o  = scl_ff[1] & ~scl_d;
  assign fall_o  = ~scl_ff[1] & scl_d;
endmodule

// File: rtl/smb_fsm.sv
module smb_fsm
  import smb_pkg::*;
#(
  parameter int TIMEOUT_CYC = 3_500_000,
  localparam int TW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [SW-1:0] strap_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic [DW-1:0] ptr_o
);
  localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_CYC);

  smb_state_e    state;
  logic [3:0]    cnt;
  logic [DW-1:0] shreg;
  logic          ack_ph, rw, sda_oe, wr_en;
  logic [TW-1:0] tcnt;
  logic          to_hit;

  assign to_hit = ~scl_s_i & (tcnt == TLIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tcnt <= '0;
    else if (!act_i || scl_s_i) tcnt <= '0;
    else if (tcnt != TLIM) tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; cnt <= '0; shreg <= '0; ack_ph <= 1'b0;
      rw <= 1'b0; sda_oe <= 1'b0; wr_en <= 1'b0; ptr_o <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!act_i || to_hit || stop_i) begin
        state <= ST_IDLE; sda_oe <= 1'b0; ack_ph <= 1'b0; cnt <= '0;
      end else if (start_i) begin
        state <= ST_ADDR; sda_oe <= 1'b0; ack_ph <= 1'b0; cnt <= '0;
      end else if (rise_i) begin
        if (!ack_ph && cnt != 4'd8 &&
            state inside {ST_ADDR, ST_REG, ST_WDATA, ST_RDATA}) begin
          cnt <= cnt + 1'b1;
          if (state != ST_RDATA) shreg <= {shreg[DW-2:0], sda_s_i};
        end
      end else if (fall_i) begin
        if (ack_ph) begin
          // end of ninth clock
          ack_ph <= 1'b0; cnt <= '0; sda_oe <= 1'b0;
          case (state)
            ST_ADDR: if (rw) begin
                       state  <= ST_RDATA;
                       shreg  <= rd_data_i;
                       sda_oe <= ~rd_data_i[DW-1];
                     end else state <= ST_REG;
            ST_REG:  state <= ST_WDATA;
            default: state <= ST_WAIT;
          endcase
        end else if (cnt == 4'd8) begin
          case (state)
            ST_ADDR: if (shreg[DW-1:1] == {ADDR_HI, strap_i}) begin
                       rw <= shreg[0]; ack_ph <= 1'b1; sda_oe <= 1'b1;
                     end else state <= ST_WAIT;
            ST_REG:   begin ptr_o <= shreg; ack_ph <= 1'b1; sda_oe <= 1'b1; end
            ST_WDATA: begin wr_en <= 1'b1; ack_ph <= 1'b1; sda_oe <= 1'b1; end
            ST_RDATA: begin ack_ph <= 1'b1; sda_oe <= 1'b0; end
            default: ;
          endcase
        end else if (state == ST_RDATA && cnt != 4'd0) begin
          shreg  <= {shreg[DW-2:0], 1'b0};
          sda_oe <= ~shreg[DW-2];
        end
      end
    end
  end

  assign sda_oe_o  = sda_oe;
  assign wr_en_o   = wr_en;
  assign wr_data_o = shreg;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [DW-1:0]     rd_addr_i,
  input  logic [NST-1:0]    stat_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [NRW*DW-1:0] regs_o
);
  localparam int IW = $clog2(NRW);

  logic [DW-1:0]  q [NRW];
  logic [NST-1:0] stat_q;

  for (genvar g = 0; g < NRW; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q[g] <= reg_rst(g);
      else if (clr_i)                             q[g] <= reg_rst(g);
      else if (wr_en_i && wr_addr_i == DW'(g))    q[g] <= wr_data_i;
    end
    assign regs_o[g*DW +: DW] = q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_i;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < DW'(NRW))           rd_data_o = q[rd_addr_i[IW-1:0]];
    else if (rd_addr_i == DW'(STAT_IDX)) rd_data_o = {{(DW-NST){1'b0}}, stat_q};
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter int TIMEOUT_CYC = 3_500_000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe_o,
  input  logic [SW-1:0]  strap_i,
  input  logic [NST-1:0] sig_ok_i,
  output logic [DW-1:0]  route_o,
  output logic [DW-1:0]  emph_o,
  output logic [DW-1:0]  eq_o,
  output logic [DW-1:0]  ctrl_o
);
  logic en_q, act_w, clr_w;
  logic scl_s_w, sda_s_w, start_w, stop_w, rise_w, fall_w;
  logic wr_en_w;
  logic [DW-1:0] wr_data_w, ptr_w, rd_data_w;
  logic [NRW*DW-1:0] regs_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end
  assign act_w = en_q;
  assign clr_w = en_i ^ en_q;

  smb_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s_w), .sda_s_o(sda_s_w), .start_o(start_w),
    .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w)
  );

  smb_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk_i, .rst_ni, .act_i(act_w), .scl_s_i(scl_s_w), .sda_s_i(sda_s_w),
    .start_i(start_w), .stop_i(stop_w), .rise_i(rise_w), .fall_i(fall_w),
    .strap_i, .rd_data_i(rd_data_w), .sda_oe_o, .wr_en_o(wr_en_w),
    .wr_data_o(wr_data_w), .ptr_o(ptr_w)
  );

  smb_regfile u_regs (
    .clk_i, .rst_ni, .clr_i(clr_w), .wr_en_i(wr_en_w), .wr_addr_i(ptr_w),
    .wr_data_i(wr_data_w), .rd_addr_i(ptr_w), .stat_i(sig_ok_i),
    .rd_data_o(rd_data_w), .regs_o(regs_w)
  );

  assign route_o = regs_w[0*DW +: DW];
  assign emph_o  = regs_w[1*DW +: DW];
  assign eq_o    = regs_w[2*DW +: DW];
  assign ctrl_o  = regs_w[3*DW +: DW];
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int TIMEOUT_CYC = 3_500_000,
  localparam int CW = $clog2(TIMEOUT_CYC + 3)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       sda_oe_o,
  input logic [7:0] route_o,
  input logic [7:0] emph_o,
  input logic [7:0] eq_o,
  input logic [7:0] ctrl_o,
  input logic       scl_s,
  input logic       act,
  input logic       clr,
  input logic       wr_en,
  input logic [7:0] wr_addr
);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               low_cnt <= '0;
    else if (!act || scl_s)    low_cnt <= '0;
    else if (low_cnt <= LIM)   low_cnt <= low_cnt + 1'b1;
  end

  // R8
  scl_stall_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_cnt > LIM) |-> !sda_oe_o);

  // R7
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_i) && !$past(en_i, 2)) |-> !sda_oe_o);

  // R7
  enable_toggle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) != $past(en_i, 2)) |-> (ctrl_o == 8'h0F && route_o == 8'h00
                                         && emph_o == 8'h00 && eq_o == 8'h00));

  // R9
  drive_on_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_s));

  // R6
  high_index_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr >= 8'd4 && !clr) |=>
      ($stable(route_o) && $stable(emph_o) && $stable(eq_o) && $stable(ctrl_o)));
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sda_oe_o(sda_oe_o),
  .route_o(route_o), .emph_o(emph_o), .eq_o(eq_o), .ctrl_o(ctrl_o),
  .scl_s(scl_s_w), .act(act_w), .clr(clr_w), .wr_en(wr_en_w), .wr_addr(ptr_w)
);

// File: tb/smb_reg_slave_test.sv
`timescale 1ns/1ps
module smb_reg_slave_test;
  localparam int Q    = 4;
  localparam int TOUT = 200;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic [3:0] strap = 4'h6, sig = 4'h0;
  logic sda_oe, sda_bus;
  logic [7:0] route, emph, eq, ctrl;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe;

  smb_reg_slave #(.TIMEOUT_CYC(TOUT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .scl_i(scl_h), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .sig_ok_i(sig),
    .route_o(route), .emph_o(emph), .eq_o(eq), .ctrl_o(ctrl)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_h = 1'b1; qw(); scl_h = 1'b1; qw(); sda_h = 1'b0; qw(); scl_h = 1'b0; qw();
  endtask

  task automatic bus_stop;
    sda_h = 1'b0; qw(); scl_h = 1'b1; qw(); sda_h = 1'b1; qw(2);
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; qw(); scl_h = 1'b1; qw(2); scl_h = 1'b0; qw();
    end
  endtask

  task automatic ack_clk(input logic drv, output logic seen);
    sda_h = drv; qw(); scl_h = 1'b1; qw(); seen = sda_bus; qw(); scl_h = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b); ack_clk(1'b1, ack);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic dummy;
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_h = 1'b1; qw(); b[i] = sda_bus; qw(); scl_h = 1'b0; qw();
    end
    ack_clk(1'b1, dummy);   // host NACK
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {3'b101, strap, rd};
  endfunction

  task automatic wr_reg(input logic [7:0] r, input logic [7:0] d, output logic [2:0] a);
    bus_start(); send_byte(dev(1'b0), a[2]); send_byte(r, a[1]); send_byte(d, a[0]);
    bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] r, output logic [7:0] d, output logic [2:0] a);
    bus_start(); send_byte(dev(1'b0), a[2]); send_byte(r, a[1]);
    bus_start(); send_byte(dev(1'b1), a[0]); recv_byte(d);
    bus_stop();
  endtask

  function automatic logic [7:0] port_of(input int r);
    case (r)
      0: return route;
      1: return emph;
      2: return eq;
      default: return ctrl;
    endcase
  endfunction

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [2:0] a;
    logic [7:0] d, v;
    logic       ak;
    en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R4 reset state
    chk("R4 route", route, 8'h00); chk("R4 emph", emph, 8'h00);
    chk("R4 eq", eq, 8'h00); chk("R4 ctrl", ctrl, 8'h0F);
    chk("R4 sda idle", {7'd0, sda_oe}, 8'h00);
    for (int r = 0; r < 4; r++) begin
      rd_reg(8'(r), d, a);
      chk("R4 read", d, (r == 3) ? 8'h0F : 8'h00);
    end

    // R1 address sweep over all straps
    for (int s = 0; s < 16; s++) begin
      strap = 4'(s);
      bus_start(); send_byte({3'b101, 4'(s), 1'b0}, ak); bus_stop();
      chk("R1 match ack", {7'd0, ak}, 8'h00);
      bus_start(); send_byte({3'b101, 4'(s) ^ 4'h8, 1'b0}, ak); bus_stop();
      chk("R1 low-bit miss nack", {7'd0, ak}, 8'h01);
      bus_start(); send_byte({3'b001, 4'(s), 1'b0}, ak); bus_stop();
      chk("R1 high-bit miss nack", {7'd0, ak}, 8'h01);
    end
    strap = 4'h6;

    // R2 / R3 write and read-back sweep
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 4; k++) begin
        v = 8'((k * 8'h5B + r * 8'h11) ^ 8'h80);
        wr_reg(8'(r), v, a);
        chk("R2 write acks", {5'd0, a}, 8'h00);
        chk("R2 port", port_of(r), v);
        rd_reg(8'(r), d, a);
        chk("R3 read acks", {5'd0, a}, 8'h00);
        chk("R3 read data", d, v);
      end
    end
    wr_reg(8'd0, 8'h01, a); rd_reg(8'd0, d, a); chk("R3 lsb only", d, 8'h01);
    wr_reg(8'd1, 8'h80, a); rd_reg(8'd1, d, a); chk("R3 msb only", d, 8'h80);

    // R5 status register
    for (int s = 0; s < 16; s++) begin
      sig = 4'(s);
      rd_reg(8'd4, d, a);
      chk("R5 status", d, {4'h0, 4'(s)});
    end
    wr_reg(8'd0, 8'h3C, a);
    wr_reg(8'd4, 8'hFF, a);
    chk("R5 write ack", {5'd0, a}, 8'h00);
    chk("R5 no effect", route, 8'h3C);
    rd_reg(8'd4, d, a);
    chk("R5 still status", d, 8'h0F);

    // R6 high indices
    for (int k = 0; k < 3; k++) begin
      logic [7:0] ix;
      ix = (k == 0) ? 8'd5 : (k == 1) ? 8'd7 : 8'hFF;
      wr_reg(ix, 8'hA5, a);
      chk("R6 write ack", {5'd0, a}, 8'h00);
      chk("R6 route kept", route, 8'h3C);
      chk("R6 emph kept", emph, 8'h80);
      chk("R6 ctrl kept", ctrl, 8'(3 * 8'h5B + 3 * 8'h11) ^ 8'h80);
      rd_reg(ix, d, a);
      chk("R6 read zero", d, 8'h00);
    end

    // R1 ignore bus after mismatch
    bus_start(); send_byte({3'b100, strap, 1'b0}, ak);
    chk("R1 miss nack", {7'd0, ak}, 8'h01);
    send_byte(8'h00, ak); chk("R1 ignored index", {7'd0, ak}, 8'h01);
    send_byte(8'h99, ak); chk("R1 ignored data", {7'd0, ak}, 8'h01);
    bus_stop();
    chk("R1 route kept", route, 8'h3C);

    // R9 STOP before data byte
    bus_start(); send_byte(dev(1'b0), ak); send_byte(8'h00, ak); bus_stop();
    chk("R9 stop abort", route, 8'h3C);

    // R7 enable gating and toggle clear
    wr_reg(8'd2, 8'h77, a);
    en = 1'b0; repeat (5) @(negedge clk);
    chk("R7 clear on fall route", route, 8'h00);
    chk("R7 clear on fall eq", eq, 8'h00);
    chk("R7 clear on fall ctrl", ctrl, 8'h0F);
    bus_start(); send_byte(dev(1'b0), ak); bus_stop();
    chk("R7 disabled nack", {7'd0, ak}, 8'h01);
    en = 1'b1; repeat (5) @(negedge clk);
    wr_reg(8'd3, 8'h81, a);
    chk("R7 re-enabled write", ctrl, 8'h81);
    en = 1'b0; repeat (3) @(negedge clk);
    en = 1'b1; repeat (3) @(negedge clk);
    chk("R7 clear on toggle", ctrl, 8'h0F);

    // R8 SCL stall while the ack is being driven
    bus_start(); send_bits(dev(1'b0));
    chk("R8 ack driven", {7'd0, sda_oe}, 8'h01);
    repeat (TOUT + 20) @(negedge clk);
    chk("R8 released", {7'd0, sda_oe}, 8'h00);
    bus_stop();
    wr_reg(8'd1, 8'h5A, a);
    chk("R8 recover ack", {5'd0, a}, 8'h00);
    chk("R8 recover data", emph, 8'h5A);

    summary();
  end
endmodule